// File: doc/BRIEF.md
# Storage Port Error Recovery Controller

This block is the per-port error handler of a serial storage host adapter. It takes single-cycle error event pulses from the rest of the port, latches each one into its own interrupt status bit, and raises one interrupt line through a per-bit enable mask. Software clears status bits by writing ones.

Errors come in two classes. Any of the four fatal classes locks the port: the running flag drops, new commands may not be issued, DMA-setup frames for queued commands are not acknowledged, and received frames are thrown away without posting. Software must drop the start bit and raise it again to restart the port. Frame posting resumes once the start bit has been low since the fatal error and then either a device reset or a new command arrives. Non-fatal errors only raise their status bit.

A fatal error also asks the link to escape the frame in flight. That request stays up until the link reports idle or a timeout runs out. Status and interrupt are raised at once and do not wait for any reply from the device, which may be hung.

Top module: `stor_recov_top`

## Requirements
- R1: An `err_evt` pulse sets the matching `irq_status` bit on the next cycle. The bits are: 0 host bus fatal, 1 host bus data, 2 interface fatal, 3 task file error, 4 interface non-fatal, 5 overflow. Bits 0 to 3 are the fatal class.
- R2: A one in `sts_clr` clears that status bit at the next edge. If an event for the same bit arrives in the same cycle, the set wins.
- R3: `irq` is high exactly when some status bit and its `sts_en` bit are both high.
- R4: In the cycle after a fatal-class event, `cmd_running`, `cmd_issue_ok` and `dma_setup_ack_ok` are all low.
- R5: After a fatal event the port stays locked while `start_bit` is held high. It runs again (`cmd_running`=1) one cycle after `start_bit` is sampled high following at least one cycle in which it was sampled low.
- R6: A non-fatal event (bit 4 or 5) sets its status bit and leaves a running port running.
- R7: `frame_post` follows `frame_rx` in the same cycle, except after a fatal event. From then on it stays low until `start_bit` has been sampled low and afterwards `dev_reset` or `new_cmd` is sampled high.
- R8: A `dev_reset` that releases the frame gate does not by itself set `cmd_running`.
- R9: A fatal event raises `link_escape` on the next cycle. The request drops one cycle after `link_idle` is sampled high.
- R10: With `link_idle` held low, `link_escape` stays high for exactly ESC_TIMEOUT cycles (1024 by default).
- R11: Events in the same cycle are all latched, and fatal wins. A fatal event with a non-fatal one, or with a start-bit set that would restart the port, leaves the port locked.
- R12: After reset all status bits, `irq`, `cmd_running`, the gates and `link_escape` are low, and `frame_post` follows `frame_rx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_evt | input | 6 | Error event pulses, one bit per class |
| sts_clr | input | 6 | Write-one-to-clear strobes for the status bits |
| sts_en | input | 6 | Per-bit interrupt enables |
| start_bit | input | 1 | Software start control, level |
| dev_reset | input | 1 | Device reset request pulse |
| new_cmd | input | 1 | New command sent to the device, pulse |
| frame_rx | input | 1 | Received-frame notification |
| link_idle | input | 1 | Link reports quiet |
| irq_status | output | 6 | Latched interrupt status bits |
| irq | output | 1 | Interrupt request |
| cmd_running | output | 1 | Port command engine running |
| cmd_issue_ok | output | 1 | New command issue allowed |
| dma_setup_ack_ok | output | 1 | Queued DMA-setup acknowledge allowed |
| frame_post | output | 1 | Received frame may be posted |
| link_escape | output | 1 | Request to abandon the frame in flight |

## Verification
Two things can land on the same clock edge: a fatal event and the start-bit set that would otherwise restart a stopped port. A fatal event can also arrive together with a non-fatal one. The bench drives a task-file error in the same cycle that `start_bit` rises after a low cycle, and checks that the port stays locked. It also drives a host-bus fatal and an overflow together, and checks that both status bits latch while the running flag drops. The status/clear collision is judged through the vector table, which places a set and a clear on the same bit in one row.

// File: rtl/stor_recov_pkg.sv
// Shared definitions for the storage port error recovery controller.
// Assumes six error classes; the lowest four are fatal.
package stor_recov_pkg;
    localparam int NUM_EV = 6;
    localparam logic [NUM_EV-1:0] FATAL_MASK = 6'b00_1111;

    typedef enum logic [1:0] {
        ST_STOPPED = 2'd0,
        ST_RUNNING = 2'd1,
        ST_FATAL   = 2'd2
    } port_state_e;
endpackage

// File: rtl/stor_recov_status.sv
// Interrupt status latch bank with write-one-to-clear and a masked interrupt.
// Assumes events are single-cycle pulses; a set beats a clear on the same bit.
module stor_recov_status
    import stor_recov_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] evt,
    input  logic [NUM_EV-1:0] clr,
    input  logic [NUM_EV-1:0] en,
    output logic [NUM_EV-1:0] sts,
    output logic              irq
);
    logic [NUM_EV-1:0] sts_q;

    for (genvar gi = 0; gi < NUM_EV; gi++) begin : g_bit
        // Hold one status bit: set by its event, cleared by its strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) sts_q[gi] <= 1'b0;
            else        sts_q[gi] <= evt[gi] | (sts_q[gi] & ~clr[gi]);
        end
    end

    // Combine enabled status bits into the interrupt line.
    always_comb irq = |(sts_q & en);

    assign sts = sts_q;

    AST_STS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((sts_q & $past(evt)) == $past(evt))); // R1
    AST_STS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~evt)) |=> ((sts_q & $past(clr & ~evt)) == '0)); // R2
endmodule

// File: rtl/stor_recov_fsm.sv
// Port run/fatal state machine plus the received-frame discard gate.
// Assumes start is a level from software; fatal events win over any other input.
module stor_recov_fsm
    import stor_recov_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fatal_any,
    input  logic        start,
    input  logic        dev_reset,
    input  logic        new_cmd,
    output port_state_e state,
    output logic        discard
);
    port_state_e state_q, state_d;
    logic        discard_q;
    logic        armed_q;

    // Choose the next port state; fatal takes priority.
    always_comb begin
        state_d = state_q;
        if (fatal_any) begin
            state_d = ST_FATAL;
        end else begin
            case (state_q)
                ST_STOPPED: if (start)  state_d = ST_RUNNING;
                ST_RUNNING: if (!start) state_d = ST_STOPPED;
                ST_FATAL:   if (!start) state_d = ST_STOPPED;
                default:                state_d = ST_STOPPED;
            endcase
        end
    end

    // Register the port state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    // Track the discard gate and whether a start clear has armed its release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            discard_q <= 1'b0;
            armed_q   <= 1'b0;
        end else if (fatal_any) begin
            discard_q <= 1'b1;
            armed_q   <= 1'b0;
        end else if (discard_q) begin
            if (armed_q && (dev_reset || new_cmd)) begin
                discard_q <= 1'b0;
                armed_q   <= 1'b0;
            end else if (!start) begin
                armed_q   <= 1'b1;
            end
        end
    end

    assign state   = state_q;
    assign discard = discard_q;

    AST_FATAL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_any |=> (state_q == ST_FATAL && discard_q)); // R4
    AST_NO_DIRECT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FATAL) |=> (state_q != ST_RUNNING)); // R5
    AST_NONFATAL_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUNNING && start && !fatal_any) |=> (state_q == ST_RUNNING)); // R6
    AST_GATE_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (discard_q && !armed_q) |=> discard_q); // R7
    AST_DEVRST_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_reset && !start && state_q != ST_RUNNING) |=> (state_q != ST_RUNNING)); // R8
endmodule

// File: rtl/stor_recov_escape.sv
// Link escape request with idle-or-timeout release.
// Assumes link_idle is synchronous; a trigger while active is absorbed.
module stor_recov_escape #(
    parameter int ESC_TIMEOUT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic link_idle,
    output logic escape
);
    localparam int CW = (ESC_TIMEOUT > 1) ? $clog2(ESC_TIMEOUT) : 1;
    localparam logic [CW-1:0] LAST = CW'(ESC_TIMEOUT - 1);

    logic          esc_q;
    logic [CW-1:0] cnt_q;

    // Raise escape on trigger, drop on idle or when the window is spent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esc_q <= 1'b0;
            cnt_q <= '0;
        end else if (!esc_q) begin
            cnt_q <= '0;
            if (trig) esc_q <= 1'b1;
        end else if (link_idle || cnt_q == LAST) begin
            esc_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign escape = esc_q;

    AST_ESC_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(esc_q) |-> $past(trig)); // R9
    AST_ESC_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (esc_q && link_idle) |=> !esc_q); // R9
    AST_ESC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (esc_q && cnt_q == LAST) |=> !esc_q); // R10
endmodule

// File: rtl/stor_recov_top.sv
// Per-port error recovery controller: status latching, fatal lockout and
// link escape. Assumes all inputs are synchronous to clk.
module stor_recov_top
    import stor_recov_pkg::*;
#(
    parameter int ESC_TIMEOUT = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] err_evt,
    input  logic [NUM_EV-1:0] sts_clr,
    input  logic [NUM_EV-1:0] sts_en,
    input  logic              start_bit,
    input  logic              dev_reset,
    input  logic              new_cmd,
    input  logic              frame_rx,
    input  logic              link_idle,
    output logic [NUM_EV-1:0] irq_status,
    output logic              irq,
    output logic              cmd_running,
    output logic              cmd_issue_ok,
    output logic              dma_setup_ack_ok,
    output logic              frame_post,
    output logic              link_escape
);
    logic        fatal_any;
    port_state_e state;
    logic        discard;

    // Detect any fatal-class event this cycle.
    always_comb fatal_any = |(err_evt & FATAL_MASK);

    stor_recov_status u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (err_evt),
        .clr   (sts_clr),
        .en    (sts_en),
        .sts   (irq_status),
        .irq   (irq)
    );

    stor_recov_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fatal_any (fatal_any),
        .start     (start_bit),
        .dev_reset (dev_reset),
        .new_cmd   (new_cmd),
        .state     (state),
        .discard   (discard)
    );

    stor_recov_escape #(.ESC_TIMEOUT(ESC_TIMEOUT)) u_escape (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (fatal_any),
        .link_idle (link_idle),
        .escape    (link_escape)
    );

    // Decode the state into the run flag and the issue/acknowledge gates.
    always_comb begin
        cmd_running      = (state == ST_RUNNING);
        cmd_issue_ok     = cmd_running;
        dma_setup_ack_ok = cmd_running;
        frame_post       = frame_rx & ~discard;
    end

    AST_FATAL_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_any |=> (!cmd_issue_ok && !dma_setup_ack_ok)); // R4
    AST_FATAL_ESCAPE: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_any |=> link_escape); // R9
endmodule

// File: tb/stor_recov_top_bench.sv
module stor_recov_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] err_evt = '0, sts_clr = '0, sts_en = '0;
    logic       start_bit = 0, dev_reset = 0, new_cmd = 0, frame_rx = 0, link_idle = 0;
    logic [5:0] irq_status;
    logic       irq, cmd_running, cmd_issue_ok, dma_setup_ack_ok, frame_post, link_escape;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    stor_recov_top u_stor_recov_top (
        .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .sts_clr(sts_clr), .sts_en(sts_en),
        .start_bit(start_bit), .dev_reset(dev_reset), .new_cmd(new_cmd), .frame_rx(frame_rx),
        .link_idle(link_idle), .irq_status(irq_status), .irq(irq), .cmd_running(cmd_running),
        .cmd_issue_ok(cmd_issue_ok), .dma_setup_ack_ok(dma_setup_ack_ok),
        .frame_post(frame_post), .link_escape(link_escape)
    );

    // Status-path vectors: event, clear, enable, expected status, expected irq.
    localparam int NV = 8;
    localparam logic [5:0] V_EVT [NV] = '{6'h01, 6'h10, 6'h00, 6'h20, 6'h08, 6'h06, 6'h00, 6'h30};
    localparam logic [5:0] V_CLR [NV] = '{6'h00, 6'h00, 6'h01, 6'h10, 6'h08, 6'h28, 6'h3F, 6'h00};
    localparam logic [5:0] V_EN  [NV] = '{6'h3F, 6'h01, 6'h01, 6'h20, 6'h00, 6'h04, 6'h3F, 6'h10};
    localparam logic [5:0] V_STS [NV] = '{6'h01, 6'h11, 6'h10, 6'h20, 6'h28, 6'h06, 6'h00, 6'h30};
    localparam logic       V_IRQ [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock: registers update, then return at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Present a frame in this cycle and check the combinational post.
    task automatic frame_check(input string req, input logic exp);
        frame_rx = 1'b1;
        #1;
        check(req, frame_post, exp);
        frame_rx = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int esc_cycles;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R12 reset state
        check("R12 status", irq_status, 6'h00);
        check("R12 irq", irq, 1'b0);
        check("R12 running", {cmd_running, cmd_issue_ok, dma_setup_ack_ok}, 3'b000);
        check("R12 escape", link_escape, 1'b0);
        frame_check("R12 frame_post", 1'b1);

        // R1 R2 R3 vector table
        for (int i = 0; i < NV; i++) begin
            err_evt = V_EVT[i]; sts_clr = V_CLR[i]; sts_en = V_EN[i];
            step();
            err_evt = '0; sts_clr = '0;
            check($sformatf("R1/R2 status row %0d", i), irq_status, V_STS[i]);
            check($sformatf("R3 irq row %0d", i), irq, V_IRQ[i]);
        end
        // Reset state machine and gates from the table's fatal events.
        sts_clr = 6'h3F; link_idle = 1'b1; step(); sts_clr = '0; link_idle = 1'b0;
        rst_n = 1'b0; step(); rst_n = 1'b1; step();

        // R5 plain start
        start_bit = 1'b1; step();
        check("R5 start runs", {cmd_running, cmd_issue_ok, dma_setup_ack_ok}, 3'b111);
        // R6 non-fatal keeps running
        err_evt = 6'h10; step(); err_evt = '0;
        check("R6 running", cmd_running, 1'b1);
        check("R6 status", irq_status, 6'h10);
        frame_check("R7 post before fatal", 1'b1);

        // R4 R9 fatal
        err_evt = 6'h04; step(); err_evt = '0;
        check("R4 gates", {cmd_running, cmd_issue_ok, dma_setup_ack_ok}, 3'b000);
        check("R9 escape up", link_escape, 1'b1);
        frame_check("R7 discard after fatal", 1'b0);
        repeat (3) step();
        check("R5 start held stays locked", cmd_running, 1'b0);
        link_idle = 1'b1; step(); link_idle = 1'b0;
        check("R9 escape drops on idle", link_escape, 1'b0);
        dev_reset = 1'b1; step(); dev_reset = 1'b0;
        frame_check("R7 reset without clear ignored", 1'b0);

        // R8 release by device reset after clear
        start_bit = 1'b0; step();
        dev_reset = 1'b1; step(); dev_reset = 1'b0;
        frame_check("R8 gate released", 1'b1);
        check("R8 no run from reset", cmd_running, 1'b0);
        start_bit = 1'b1; step();
        check("R5 restart after clear", cmd_running, 1'b1);

        // R11 fatal with non-fatal
        sts_clr = 6'h3F; step(); sts_clr = '0;
        err_evt = 6'h21; step(); err_evt = '0;
        check("R11 both latched", irq_status, 6'h21);
        check("R11 fatal wins", cmd_running, 1'b0);
        link_idle = 1'b1; step(); link_idle = 1'b0;

        // R11 fatal with restart edge, then R10 timeout
        start_bit = 1'b0; step();
        start_bit = 1'b1; err_evt = 6'h08; step(); err_evt = '0;
        check("R11 fatal beats restart", cmd_running, 1'b0);
        esc_cycles = 0;
        while (link_escape && esc_cycles < 3000) begin
            esc_cycles++;
            step();
        end
        check("R10 escape window", esc_cycles, 1024);

        // R7 release by new command after clear
        frame_check("R7 still discarding", 1'b0);
        start_bit = 1'b0; step();
        new_cmd = 1'b1; step(); new_cmd = 1'b0;
        frame_check("R7 new command releases", 1'b1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule